// File: doc/BRIEF.md
# PWM Performance-Emulation Power Sequencer

This block lets a system that can only run flat out or sit in a low-voltage idle state behave as if it had eight performance levels. It drives a power request shaped like a PWM waveform. Each frame is divided into eight equal time slots. For a programmed level of N eighths, the request is held high (the mark) for the first N slots, and the remaining slots form the space.

At the end of the mark the block raises a sleep interrupt. It keeps power requested until the processor reports that it is waiting for an interrupt while the supply is flagged ready, and only then drops the request. At the frame end the block raises the request again together with a wake-up interrupt. Frame timing restarts at the edge where power is requested, so the supply ramp eats into the mark.

Writing a new level restarts the frame at once. A maximum-performance request overrides everything: the frame is aborted, power is requested, and a wake-up interrupt is raised. When the request is withdrawn, a fresh frame starts at the programmed level. Slot length is counted in cycles where the slot-tick enable is high. The reset length is 100 ticks, which is 100 µs with a 1 MHz tick.

Top module: `pwm_perf_seq`

## Requirements
- R1: During and right after reset, `pwr_req_o` is 1 and both interrupts are 0. The level resets to 8 and the slot length resets to `SLOT_RST` (100) ticks.
- R2: Take a frame start edge E0 (a level write, an override release, or a frame end) with the tick held high, a level N below 8 and a slot length L. Then `sleep_irq_o` goes high at edge E0+N·L, and power stays requested until then.
- R3: A slot lasts L ticks, where L is the slot-length register and 0 is treated as 1. Only cycles with `tick_i`=1 count. Writing the slot length does not restart the frame.
- R4: At level 8 every slot is mark: `pwr_req_o` stays 1 and no sleep interrupt is raised.
- R5: After the sleep interrupt, `pwr_req_o` stays 1 until `wfi_ack_i` and `vready_i` are both sampled 1. It falls at that edge.
- R6: When a frame ends from the space, `pwr_req_o` rises and `wake_irq_o` is set at edge E0+8·L.
- R7: If the frame ends before the acknowledge is accepted, the next frame starts with power still requested and no wake-up interrupt.
- R8: Level writes (`lvl_wr_i`) are clamped: 0 becomes 1 and values above 8 become 8. Outside an override, a level write restarts the frame at its edge.
- R9: An `icr_wr_i` write with bit 0 set clears the sleep interrupt, and one with bit 1 set clears the wake-up interrupt. Each bit acts alone. A set in the same cycle wins over a clear.
- R10: While `maxperf_i` is 1, from the next edge `pwr_req_o` is 1 and no sleep interrupt is raised. Entering the override sets `wake_irq_o`.
- R11: When `maxperf_i` falls, a new frame starts at that edge using the programmed level. Level writes made during the override update that level but do not end the override.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lvl_wr_i | input | 1 | Level write strobe |
| lvl_data_i | input | LVL_W | Requested level in eighths |
| slot_wr_i | input | 1 | Slot-length write strobe |
| slot_data_i | input | SLOT_W | Slot length in ticks |
| tick_i | input | 1 | Slot-tick enable |
| wfi_ack_i | input | 1 | Processor wait-for-interrupt acknowledge |
| vready_i | input | 1 | Supply at full voltage |
| maxperf_i | input | 1 | Maximum-performance override |
| icr_wr_i | input | 1 | Interrupt-clear write strobe |
| icr_data_i | input | 2 | Clear mask: bit 0 sleep, bit 1 wake |
| pwr_req_o | output | 1 | Power request (PWM) |
| sleep_irq_o | output | 1 | Sleep interrupt |
| wake_irq_o | output | 1 | Wake-up interrupt |

## Verification
A wrong sequencer state shows at the ports within one frame. A slot counter that is off by a tick moves the sleep interrupt edge by a whole multiple of the slot count, and the bench measures that edge cycle-exactly. A state that skips the handshake drops power one cycle after the mark, before the acknowledge is given. A missing override shows on the first edge after `maxperf_i` rises, and a lost level shows as a wrong mark length after release.

// File: rtl/pwm_perf_pkg.sv
package pwm_perf_pkg;
  typedef enum logic [2:0] {
    ST_IDLE_RESET,
    ST_MARK,
    ST_WAIT_ACK,
    ST_SPACE,
    ST_MAXPERF
  } seq_state_e;

  localparam int unsigned IRQ_N     = 2;
  localparam int unsigned IRQ_SLEEP = 0;
  localparam int unsigned IRQ_WAKE  = 1;
endpackage

// File: rtl/pwm_slot_timer.sv
module pwm_slot_timer #(
  parameter int unsigned SLOTS  = 8,
  parameter int unsigned SLOT_W = 16,
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              restart_i,
  input  logic              tick_i,
  input  logic [SLOT_W-1:0] slot_len_i,
  output logic [IDX_W-1:0]  slot_idx_o,
  output logic              slot_end_o,
  output logic              frame_end_o
);
  logic [SLOT_W-1:0] cnt_q;
  logic [IDX_W-1:0]  idx_q;
  logic [SLOT_W-1:0] len_m1;

  assign len_m1      = (slot_len_i == '0) ? '0 : slot_len_i - SLOT_W'(1);
  // >= so that shortening the length mid-slot ends the slot promptly
  assign slot_end_o  = tick_i && !restart_i && (cnt_q >= len_m1);
  assign frame_end_o = slot_end_o && (idx_q == IDX_W'(SLOTS - 1));
  assign slot_idx_o  = idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (restart_i) begin
      cnt_q <= '0;
      idx_q <= '0;
    end else if (tick_i) begin
      if (slot_end_o) begin
        cnt_q <= '0;
        idx_q <= frame_end_o ? '0 : idx_q + IDX_W'(1);
      end else begin
        cnt_q <= cnt_q + SLOT_W'(1);
      end
    end
  end

  assert_tick_gates_slot_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!tick_i && !restart_i) |=> $stable(idx_q));
endmodule

// File: rtl/pwm_irq_bit.sv
module pwm_irq_bit (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    irq_o <= 1'b0;
    else if (set_i) irq_o <= 1'b1;
    else if (clr_i) irq_o <= 1'b0;
  end
endmodule

// File: rtl/pwm_seq_fsm.sv
module pwm_seq_fsm
  import pwm_perf_pkg::*;
#(
  parameter int unsigned SLOTS = 8,
  localparam int unsigned LVL_W = $clog2(SLOTS + 1),
  localparam int unsigned IDX_W = $clog2(SLOTS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             lvl_wr_i,
  input  logic [LVL_W-1:0] lvl_data_i,
  input  logic             maxperf_i,
  input  logic             wfi_ack_i,
  input  logic             vready_i,
  input  logic [IDX_W-1:0] slot_idx_i,
  input  logic             slot_end_i,
  input  logic             frame_end_i,
  output logic             restart_o,
  output logic             pwr_req_o,
  output logic             sleep_set_o,
  output logic             wake_set_o
);
  seq_state_e       state_q, state_d;
  logic [LVL_W-1:0] lvl_q, lvl_clamped;
  logic             mark_end, full;

  always_comb begin
    lvl_clamped = lvl_data_i;
    if (lvl_data_i == '0)                    lvl_clamped = LVL_W'(1);
    else if (lvl_data_i > LVL_W'(SLOTS))     lvl_clamped = LVL_W'(SLOTS);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       lvl_q <= LVL_W'(SLOTS);
    else if (lvl_wr_i) lvl_q <= lvl_clamped;
  end

  assign full     = (lvl_q == LVL_W'(SLOTS));
  assign mark_end = slot_end_i && (slot_idx_i == IDX_W'(lvl_q - LVL_W'(1)));

  always_comb begin
    state_d     = state_q;
    sleep_set_o = 1'b0;
    wake_set_o  = 1'b0;
    if (maxperf_i) begin
      state_d    = ST_MAXPERF;
      wake_set_o = (state_q != ST_MAXPERF);
    end else if (state_q == ST_IDLE_RESET || state_q == ST_MAXPERF || lvl_wr_i) begin
      state_d = ST_MARK;
    end else begin
      unique case (state_q)
        ST_MARK: if (mark_end && !full) begin
          state_d     = ST_WAIT_ACK;
          sleep_set_o = 1'b1;
        end
        ST_WAIT_ACK: begin
          if (frame_end_i)                 state_d = ST_MARK;   // no drop, no wake
          else if (wfi_ack_i && vready_i)  state_d = ST_SPACE;
        end
        ST_SPACE: if (frame_end_i) begin
          state_d    = ST_MARK;
          wake_set_o = 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign restart_o = maxperf_i || lvl_wr_i ||
                     (state_q == ST_MAXPERF) || (state_q == ST_IDLE_RESET);
  assign pwr_req_o = (state_q != ST_SPACE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= ST_IDLE_RESET;
    else         state_q <= state_d;
  end

  assert_drop_needs_ack_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(pwr_req_o) |-> $past(wfi_ack_i && vready_i && state_q == ST_WAIT_ACK));
  assert_override_power_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    maxperf_i |=> (pwr_req_o && state_q == ST_MAXPERF));
  assert_full_no_sleep_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full && !lvl_wr_i) |-> !sleep_set_o);
  assert_rise_wakes_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_req_o) |-> $past(wake_set_o || lvl_wr_i));
  assert_level_range_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lvl_q >= LVL_W'(1)) && (lvl_q <= LVL_W'(SLOTS)));
  assert_late_ack_keeps_power_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_WAIT_ACK && frame_end_i && !maxperf_i && !lvl_wr_i)
      |=> (pwr_req_o && !wake_set_o && state_q == ST_MARK));
endmodule

// File: rtl/pwm_perf_seq.sv
module pwm_perf_seq
  import pwm_perf_pkg::*;
#(
  parameter int unsigned SLOTS    = 8,
  parameter int unsigned SLOT_W   = 16,
  parameter int unsigned SLOT_RST = 100,
  localparam int unsigned LVL_W   = $clog2(SLOTS + 1),
  localparam int unsigned IDX_W   = $clog2(SLOTS)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              lvl_wr_i,
  input  logic [LVL_W-1:0]  lvl_data_i,
  input  logic              slot_wr_i,
  input  logic [SLOT_W-1:0] slot_data_i,
  input  logic              tick_i,
  input  logic              wfi_ack_i,
  input  logic              vready_i,
  input  logic              maxperf_i,
  input  logic              icr_wr_i,
  input  logic [1:0]        icr_data_i,
  output logic              pwr_req_o,
  output logic              sleep_irq_o,
  output logic              wake_irq_o
);
  logic [SLOT_W-1:0] slot_len_q;
  logic [IDX_W-1:0]  slot_idx;
  logic              slot_end, frame_end, restart;
  logic [IRQ_N-1:0]  irq_set, irq_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        slot_len_q <= SLOT_W'(SLOT_RST);
    else if (slot_wr_i) slot_len_q <= slot_data_i;
  end

  pwm_slot_timer #(.SLOTS(SLOTS), .SLOT_W(SLOT_W)) u_timer (
    .clk_i, .rst_ni,
    .restart_i  (restart),
    .tick_i,
    .slot_len_i (slot_len_q),
    .slot_idx_o (slot_idx),
    .slot_end_o (slot_end),
    .frame_end_o(frame_end)
  );

  pwm_seq_fsm #(.SLOTS(SLOTS)) u_fsm (
    .clk_i, .rst_ni,
    .lvl_wr_i, .lvl_data_i, .maxperf_i, .wfi_ack_i, .vready_i,
    .slot_idx_i (slot_idx),
    .slot_end_i (slot_end),
    .frame_end_i(frame_end),
    .restart_o  (restart),
    .pwr_req_o,
    .sleep_set_o(irq_set[IRQ_SLEEP]),
    .wake_set_o (irq_set[IRQ_WAKE])
  );

  for (genvar g = 0; g < IRQ_N; g++) begin : g_irq
    pwm_irq_bit u_irq (
      .clk_i, .rst_ni,
      .set_i(irq_set[g]),
      .clr_i(icr_wr_i && icr_data_i[g]),
      .irq_o(irq_q[g])
    );
  end

  assign sleep_irq_o = irq_q[IRQ_SLEEP];
  assign wake_irq_o  = irq_q[IRQ_WAKE];

  assert_sleep_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icr_wr_i && icr_data_i[0] && !irq_set[IRQ_SLEEP]) |=> !sleep_irq_o);
  assert_wake_clear_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (icr_wr_i && icr_data_i[1] && !irq_set[IRQ_WAKE]) |=> !wake_irq_o);
  assert_override_wake_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(maxperf_i) |=> wake_irq_o);
endmodule

// File: tb/pwm_perf_seq_tb.sv
`timescale 1ns/1ps
module pwm_perf_seq_tb;
  logic        clk_i = 1'b0, rst_ni = 1'b0;
  logic        lvl_wr_i = 0, slot_wr_i = 0, icr_wr_i = 0;
  logic [3:0]  lvl_data_i = '0;
  logic [15:0] slot_data_i = '0;
  logic [1:0]  icr_data_i = '0;
  logic        tick_i = 1, wfi_ack_i = 1, vready_i = 1, maxperf_i = 0;
  logic        pwr_req_o, sleep_irq_o, wake_irq_o;
  int          n_checks = 0, n_fail = 0;
  bit          done = 0;

  always #4 clk_i = ~clk_i;

  pwm_perf_seq u_dut (.*);

  typedef struct packed {
    int lvl; int len; int exp_mark; int exp_low;
  } vec_t;
  localparam vec_t VECS [6] = '{
    '{4, 3, 12, 11}, '{6, 2, 12, 3}, '{1, 4, 4, 27},
    '{7, 2, 14, 1},  '{0, 2, 2, 13}, '{3, 5, 15, 24}
  };

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // level write with both interrupts cleared in the same cycle
  task automatic write_level(input int v);
    @(negedge clk_i);
    lvl_wr_i = 1; lvl_data_i = 4'(v); icr_wr_i = 1; icr_data_i = 2'b11;
    @(negedge clk_i);
    lvl_wr_i = 0; icr_wr_i = 0; icr_data_i = 2'b00;
  endtask

  task automatic write_slot(input int v);
    @(negedge clk_i);
    slot_wr_i = 1; slot_data_i = 16'(v);
    @(negedge clk_i);
    slot_wr_i = 0;
  endtask

  task automatic write_icr(input logic [1:0] m);
    icr_wr_i = 1; icr_data_i = m;
    @(negedge clk_i);
    icr_wr_i = 0; icr_data_i = 2'b00;
  endtask

  task automatic wait_sleep(inout int k);
    while (!sleep_irq_o && k < 5000) begin @(negedge clk_i); k++; end
  endtask

  task automatic count_low(output int c);
    int g = 0;
    while (pwr_req_o && g < 5000) begin @(negedge clk_i); g++; end
    c = 0;
    while (!pwr_req_o && c < 5000) begin @(negedge clk_i); c++; end
  endtask

  initial begin
    repeat (150000) @(posedge clk_i);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    int k, c;
    bit ok;
    repeat (3) @(negedge clk_i);
    check(pwr_req_o && !sleep_irq_o && !wake_irq_o, "R1 reset outputs", {pwr_req_o, sleep_irq_o, wake_irq_o}, 3'b100);
    rst_ni = 1;
    repeat (2) @(negedge clk_i);
    check(pwr_req_o && !sleep_irq_o && !wake_irq_o, "R1 after release", {pwr_req_o, sleep_irq_o, wake_irq_o}, 3'b100);

    // R1/R3: default slot length of 100 ticks
    write_level(1); k = 0; wait_sleep(k);
    check(k == 100, "R1 R3 default slot length mark", k, 100);

    // table walk: R2 mark timing, R5 drop, R6 wake at frame end
    foreach (VECS[i]) begin
      write_slot(VECS[i].len);
      write_level(VECS[i].lvl);
      k = 0; wait_sleep(k);
      check(k == VECS[i].exp_mark, "R2 mark length", k, VECS[i].exp_mark);
      count_low(c);
      check(c == VECS[i].exp_low, "R5 space length", c, VECS[i].exp_low);
      check(wake_irq_o && pwr_req_o, "R6 wake at frame end", {wake_irq_o, pwr_req_o}, 2'b11);
    end

    // R4/R8: level 12 clamps to 8, full duty
    write_slot(2); write_level(12);
    ok = 1;
    repeat (40) begin @(negedge clk_i); if (!pwr_req_o || sleep_irq_o) ok = 0; end
    check(ok, "R4 R8 full level no sleep", ok, 1);

    // R3: ticks gated
    write_slot(3);
    tick_i = 0; write_level(2);
    repeat (20) @(negedge clk_i);
    tick_i = 1; k = 20; wait_sleep(k);
    check(k == 26, "R3 tick gating", k, 26);

    // R5/R7/R6/R9 handshake sequence, L=2 level 2
    wfi_ack_i = 0;
    write_slot(2); write_level(2);
    k = 0; wait_sleep(k);
    check(k == 4, "R2 mark level2", k, 4);
    ok = 1;
    while (k < 16) begin @(negedge clk_i); k++; if (k < 16 && !pwr_req_o) ok = 0; end
    check(ok && pwr_req_o, "R5 power held without ack", pwr_req_o, 1);
    check(!wake_irq_o, "R7 no wake on late ack", wake_irq_o, 0);
    vready_i = 0; wfi_ack_i = 1;
    while (k < 24) begin @(negedge clk_i); k++; end
    check(pwr_req_o, "R5 power held without vready", pwr_req_o, 1);
    vready_i = 1;
    @(negedge clk_i); k++;
    check(!pwr_req_o, "R5 drop after ack and vready", pwr_req_o, 0);
    while (k < 32) begin @(negedge clk_i); k++; end
    check(wake_irq_o && pwr_req_o, "R6 wake after space", {wake_irq_o, pwr_req_o}, 2'b11);
    check(sleep_irq_o, "R9 sleep still pending", sleep_irq_o, 1);
    write_icr(2'b01); k++;
    check(!sleep_irq_o && wake_irq_o, "R9 clear sleep only", {sleep_irq_o, wake_irq_o}, 2'b01);
    write_icr(2'b10); k++;
    check(!sleep_irq_o && !wake_irq_o, "R9 clear wake", {sleep_irq_o, wake_irq_o}, 2'b00);
    @(negedge clk_i); k++;
    write_icr(2'b01); k++;
    check(k == 36 && sleep_irq_o, "R9 set wins over clear", sleep_irq_o, 1);

    // R8: mid-frame restart
    write_slot(4); write_level(4);
    repeat (10) @(negedge clk_i);
    write_level(6);
    k = 0; wait_sleep(k);
    check(k == 24, "R8 restart on level write", k, 24);

    // R10/R11 override
    write_level(2);
    repeat (12) @(negedge clk_i);
    check(!pwr_req_o, "R5 in space before override", pwr_req_o, 0);
    maxperf_i = 1;
    @(negedge clk_i);
    check(pwr_req_o && wake_irq_o, "R10 override power and wake", {pwr_req_o, wake_irq_o}, 2'b11);
    write_icr(2'b11);
    ok = 1;
    repeat (40) begin @(negedge clk_i); if (!pwr_req_o || sleep_irq_o) ok = 0; end
    check(ok, "R10 held during override", ok, 1);
    maxperf_i = 0;
    @(negedge clk_i);
    k = 0; wait_sleep(k);
    check(k == 8, "R11 resume programmed level", k, 8);
    maxperf_i = 1;
    repeat (5) @(negedge clk_i);
    write_level(3);
    repeat (5) @(negedge clk_i);
    check(pwr_req_o && !sleep_irq_o, "R11 write keeps override", {pwr_req_o, sleep_irq_o}, 2'b10);
    maxperf_i = 0;
    @(negedge clk_i);
    k = 0; wait_sleep(k);
    check(k == 12, "R11 level written in override", k, 12);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule